// File: doc/BRIEF.md
# Toggle-on-Write Interrupt Controller

This block collects per-channel input-change events, already detected elsewhere, into a small status register. It combines them with a per-channel enable mask and a single master enable, and drives one active-high, level-sensitive interrupt line. Software reaches the three registers through a plain single-cycle read/write port. The port sits behind a bus adapter that decodes the memory-mapped window, so the register offsets used here are fixed.

Writing a 1 to a status bit inverts that bit, and writing 0 leaves it as it is. A service routine therefore clears exactly the bits it handled in one write. A test routine can also raise a status bit on purpose to exercise the interrupt path. Hardware events always land in the status register, whatever the enables say. The enables only decide whether the output line goes high.

A build parameter can remove the controller entirely. In that case the three offsets read as zero, writes to them do nothing, and the interrupt line stays low.

Top module: `irq_tow_ctrl`

## Requirements
- R1: After reset, the master enable, the channel enable bits and the status bits all read as 0, and `irq_out` is 0.
- R2: The master enable is bit 31 of the register at byte offset 0x11C. A write to that offset stores `reg_wdata[31]`, and bits 30..0 always read as 0.
- R3: The channel enable register sits at offset 0x128. Bit 0 belongs to channel 1 and bit 1 to channel 2. A write stores `reg_wdata[1:0]`, and bits 31..2 read as 0.
- R4: The status register sits at offset 0x120 and uses the same bit assignment as R3. Writing 1 to a bit inverts it, writing 0 leaves it unchanged, and bits 31..2 read as 0.
- R5: An event pulse on `evt_in[i]`, sampled at a rising clock edge, sets status bit i even when enable bit i is clear. While the enables block it, the event does not raise `irq_out`.
- R6: If an event and a toggle write reach the same status bit at the same edge, the bit is 1 after that edge.
- R7: `irq_out` is a register. One cycle after any edge, it equals the master enable AND the OR over channels of (status AND enable), taken as they stood after that edge.
- R8: At any offset other than the three above, reads return 0 and writes change no register.
- R9: With `IRQ_PRESENT` = 0, every offset reads as 0, writes and events have no effect, and `irq_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | NUM_CH | Per-channel event pulses from the detection logic |
| irq_out | output | 1 | Level interrupt, active high, registered |

## Verification
A wrong status, enable or master-enable bit shows up in the very next read of its offset. It also shows up one cycle after the bad edge on `irq_out`, as soon as the matching enable and master enable are set. The bench runs a cycle-accurate model beside the design. Every cycle it compares the read data of the addressed offset and the interrupt line against that model, so a wrong toggle, a lost event or a missed mask shows within one cycle of the edge that caused it. It also mixes directed cases (simultaneous event and toggle, writes to unmapped offsets, an instance built without the controller) with seeded random traffic.

// File: rtl/irq_tow_pkg.sv
// Package: shared offsets, field positions and decode type for the
// toggle-on-write interrupt controller. Assumes a 32-bit data path.
package irq_tow_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned OFS_GIE = 32'h11C;
    localparam int unsigned OFS_STS = 32'h120;
    localparam int unsigned OFS_ENA = 32'h128;
    localparam int unsigned GIE_BIT = 31;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_GIE  = 2'd1,
        SEL_STS  = 2'd2,
        SEL_ENA  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_reg_decode.sv
// Address decoder: maps a byte offset onto one of the three registers.
// Assumes the full offset is compared; any other value selects nothing.
module irq_reg_decode
    import irq_tow_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_GIE = ADDR_W'(OFS_GIE);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(OFS_ENA);

    // Purpose: pick the register addressed by the current offset.
    always_comb begin
        if (addr == A_GIE)      sel = SEL_GIE;
        else if (addr == A_STS) sel = SEL_STS;
        else if (addr == A_ENA) sel = SEL_ENA;
        else                    sel = SEL_NONE;
    end
endmodule

// File: rtl/irq_enable_regs.sv
// Enable registers: holds the master enable and the per-channel mask.
// Assumes write strobes are already qualified by the address decode.
module irq_enable_regs
    import irq_tow_pkg::*;
#(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_gie,
    input  logic              wr_ena,
    input  logic [DATA_W-1:0] wdata,
    output logic              gie_q,
    output logic [NUM_CH-1:0] ena_q
);
    // Purpose: load the master enable from its bit position on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_q <= 1'b0;
        else if (wr_gie) gie_q <= wdata[GIE_BIT];
    end

    // Purpose: load the channel mask from the low bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ena_q <= '0;
        else if (wr_ena) ena_q <= wdata[NUM_CH-1:0];
    end
endmodule

// File: rtl/irq_status_bank.sv
// Status bank: one flop per channel. A write of 1 inverts the bit, and a
// hardware event sets it, with the event winning over a same-edge toggle.
// Assumes events are single-clock samples from upstream detection.
module irq_status_bank #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sts,
    input  logic [NUM_CH-1:0] tog_bits,
    input  logic [NUM_CH-1:0] evt,
    output logic [NUM_CH-1:0] sts_q
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic nxt;
        // Purpose: apply the toggle first, then let the event force a 1.
        always_comb begin
            nxt = sts_q[ch] ^ (wr_sts & tog_bits[ch]);
            if (evt[ch]) nxt = 1'b1;
        end
        // Purpose: hold the status bit for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n) sts_q[ch] <= 1'b0;
            else        sts_q[ch] <= nxt;
        end
    end
endmodule

// File: rtl/irq_out_stage.sv
// Output stage: gates masked status with the master enable and registers
// the result, so the line is free of decode glitches.
module irq_out_stage #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gie,
    input  logic [NUM_CH-1:0] ena,
    input  logic [NUM_CH-1:0] sts,
    output logic              irq_q
);
    logic pend;

    // Purpose: detect any pending, enabled channel.
    always_comb pend = gie & (|(sts & ena));

    // Purpose: register the interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend;
    end
endmodule

// File: rtl/irq_tow_ctrl.sv
// Top: toggle-on-write interrupt controller with a simple register port.
// When IRQ_PRESENT is 0 the controller is left out: reads give zero and
// the line stays low. Assumes NUM_CH is between 1 and 30.
module irq_tow_ctrl
    import irq_tow_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 12,
    parameter bit          IRQ_PRESENT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NUM_CH-1:0] evt_in,
    output logic              irq_out
);
    localparam int unsigned PAD_W = DATA_W - NUM_CH;

    logic              gie_q;
    logic [NUM_CH-1:0] ena_q;
    logic [NUM_CH-1:0] sts_q;

    if (IRQ_PRESENT) begin : g_ctrl
        reg_sel_e sel;
        logic     unused_wbits;

        assign unused_wbits = ^reg_wdata[GIE_BIT-1:NUM_CH];

        irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
            .addr (reg_addr),
            .sel  (sel)
        );

        irq_enable_regs #(.NUM_CH(NUM_CH)) u_ena (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_gie (reg_wr && sel == SEL_GIE),
            .wr_ena (reg_wr && sel == SEL_ENA),
            .wdata  (reg_wdata),
            .gie_q  (gie_q),
            .ena_q  (ena_q)
        );

        irq_status_bank #(.NUM_CH(NUM_CH)) u_sts (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sts   (reg_wr && sel == SEL_STS),
            .tog_bits (reg_wdata[NUM_CH-1:0]),
            .evt      (evt_in),
            .sts_q    (sts_q)
        );

        irq_out_stage #(.NUM_CH(NUM_CH)) u_out (
            .clk   (clk),
            .rst_n (rst_n),
            .gie   (gie_q),
            .ena   (ena_q),
            .sts   (sts_q),
            .irq_q (irq_out)
        );

        // Purpose: return the addressed register, zero-extended.
        always_comb begin
            unique case (sel)
                SEL_GIE: reg_rdata = {gie_q, {GIE_BIT{1'b0}}};
                SEL_STS: reg_rdata = {{PAD_W{1'b0}}, sts_q};
                SEL_ENA: reg_rdata = {{PAD_W{1'b0}}, ena_q};
                default: reg_rdata = '0;
            endcase
        end
    end else begin : g_none
        logic unused_inputs;
        assign unused_inputs = ^{clk, rst_n, reg_wr, reg_addr, reg_wdata, evt_in};
        assign gie_q     = 1'b0;
        assign ena_q     = '0;
        assign sts_q     = '0;
        assign reg_rdata = '0;
        assign irq_out   = 1'b0;
    end
endmodule

// File: rtl/irq_tow_chk.sv
// Checker: temporal properties of the interrupt controller, bound to the top.
module irq_tow_chk
    import irq_tow_pkg::*;
#(
    parameter int unsigned NUM_CH      = 2,
    parameter int unsigned ADDR_W      = 12,
    parameter bit          IRQ_PRESENT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [NUM_CH-1:0] evt_in,
    input logic              irq_out,
    input logic              gie_q,
    input logic [NUM_CH-1:0] ena_q,
    input logic [NUM_CH-1:0] sts_q
);
    localparam logic [ADDR_W-1:0] A_GIE = ADDR_W'(OFS_GIE);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STS);

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_q && |(sts_q & ena_q)) |=> irq_out);

    // R7
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gie_q && |(sts_q & ena_q)) |=> !irq_out);

    // R5
    evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IRQ_PRESENT && |evt_in) |=> ((sts_q & $past(evt_in)) == $past(evt_in)));

    // R4
    tow_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (IRQ_PRESENT && reg_wr && reg_addr == A_STS && evt_in == '0)
        |=> sts_q == ($past(sts_q) ^ $past(reg_wdata[NUM_CH-1:0])));

    // R2
    gie_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_GIE) |-> reg_rdata[30:0] == 31'd0);

    // R9
    absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !IRQ_PRESENT |-> (reg_rdata == 32'd0 && !irq_out));
endmodule

bind irq_tow_ctrl irq_tow_chk #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .IRQ_PRESENT (IRQ_PRESENT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .irq_out   (irq_out),
    .gie_q     (gie_q),
    .ena_q     (ena_q),
    .sts_q     (sts_q)
);

// File: tb/tb_irq_tow_ctrl.sv
`timescale 1ns/1ps
module tb_irq_tow_ctrl;
    localparam int NCH = 2;
    localparam int AW  = 12;
    localparam logic [AW-1:0] A_GIE = 12'h11C;
    localparam logic [AW-1:0] A_STS = 12'h120;
    localparam logic [AW-1:0] A_ENA = 12'h128;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_wr = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [NCH-1:0] evt_in = '0;
    logic [31:0]    rdata, rdata_n;
    logic           irq, irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic           m_gie = 1'b0;
    logic [NCH-1:0] m_ena = '0;
    logic [NCH-1:0] m_sts = '0;
    logic           m_irq = 1'b0;

    always #5 clk = ~clk;

    irq_tow_ctrl #(.NUM_CH(NCH), .ADDR_W(AW), .IRQ_PRESENT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata), .evt_in(evt_in), .irq_out(irq));

    irq_tow_ctrl #(.NUM_CH(NCH), .ADDR_W(AW), .IRQ_PRESENT(1'b0)) dut_noirq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_n), .evt_in(evt_in), .irq_out(irq_n));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        if (a == A_GIE) return {m_gie, 31'd0};
        if (a == A_STS) return {30'd0, m_sts};
        if (a == A_ENA) return {30'd0, m_ena};
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [AW-1:0] a);
        if (a == A_GIE) return "R2";
        if (a == A_STS) return "R4";
        if (a == A_ENA) return "R3";
        return "R8";
    endfunction

    // One bus cycle: drive, check reads and line, then advance the model.
    task automatic cycle(input logic wr, input logic [AW-1:0] a,
                         input logic [31:0] wd, input logic [NCH-1:0] ev,
                         output logic [31:0] rd);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = wd; evt_in = ev;
        #1;
        rd = rdata;
        chk(tag_of(a), rdata, model_read(a));
        chk("R7", {31'd0, irq}, {31'd0, m_irq});
        chk("R9", rdata_n, 32'd0);
        chk("R9", {31'd0, irq_n}, 32'd0);
        @(posedge clk);
        m_irq = m_gie & (|(m_sts & m_ena));
        if (wr && a == A_GIE) m_gie = wd[31];
        if (wr && a == A_ENA) m_ena = wd[NCH-1:0];
        m_sts = (m_sts ^ ((wr && a == A_STS) ? wd[NCH-1:0] : '0)) | ev;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        // R1: reset values seen at the ports
        reg_addr = A_GIE; #1 chk("R1", rdata, 32'd0);
        reg_addr = A_STS; #1 chk("R1", rdata, 32'd0);
        reg_addr = A_ENA; #1 chk("R1", rdata, 32'd0);
        chk("R1", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;

        // R2: only bit 31 sticks
        cycle(1'b1, A_GIE, 32'hFFFF_FFFF, '0, rd);
        cycle(1'b0, A_GIE, 32'h0, '0, rd);
        chk("R2", rd, 32'h8000_0000);
        // R3: only the channel bits stick
        cycle(1'b1, A_ENA, 32'hFFFF_FFFF, '0, rd);
        cycle(1'b0, A_ENA, 32'h0, '0, rd);
        chk("R3", rd, 32'h0000_0003);
        cycle(1'b1, A_ENA, 32'h0, '0, rd);
        // R5: event with mask clear sets status, line stays low
        cycle(1'b0, A_STS, 32'h0, 2'b01, rd);
        cycle(1'b0, A_STS, 32'h0, '0, rd);
        chk("R5", rd, 32'h1);
        cycle(1'b0, A_STS, 32'h0, '0, rd);
        chk("R5", {31'd0, irq}, 32'd0);
        // R4: toggle 0b11 over 0b01 gives 0b10; writing 0 keeps it
        cycle(1'b1, A_STS, 32'hFFFF_FFF3, '0, rd);
        cycle(1'b1, A_STS, 32'h0, '0, rd);
        chk("R4", rd, 32'h2);
        cycle(1'b0, A_STS, 32'h0, '0, rd);
        chk("R4", rd, 32'h2);
        // R6: toggle and event on bit 1 together leave it set
        cycle(1'b1, A_STS, 32'h2, 2'b10, rd);
        cycle(1'b0, A_STS, 32'h0, '0, rd);
        chk("R6", rd, 32'h2);
        // R7: enabling channel 2 raises the line one cycle later
        cycle(1'b1, A_ENA, 32'h2, '0, rd);
        cycle(1'b0, A_STS, 32'h0, '0, rd);
        chk("R7", {31'd0, irq}, 32'd0);
        cycle(1'b0, A_STS, 32'h0, '0, rd);
        chk("R7", {31'd0, irq}, 32'd1);
        // R8: unmapped offsets read zero and leave registers alone
        cycle(1'b1, 12'h124, 32'hFFFF_FFFF, '0, rd);
        cycle(1'b1, 12'h000, 32'hFFFF_FFFF, '0, rd);
        cycle(1'b0, A_ENA, 32'h0, '0, rd);
        chk("R8", rd, 32'h2);
        cycle(1'b0, A_GIE, 32'h0, '0, rd);
        chk("R8", rd, 32'h8000_0000);

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0]  a;
            logic [NCH-1:0] ev;
            case ($urandom_range(0, 4))
                0: a = A_GIE;
                1, 2: a = A_STS;
                3: a = A_ENA;
                default: a = AW'({$urandom_range(0, 1023), 2'b00});
            endcase
            ev = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
            cycle($urandom_range(0, 1) == 1, a, $urandom, ev, rd);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule